// File: doc/BRIEF.md
# I2C Master Byte Engine with Clock Stretching

This block is the bus-facing engine of an I2C controller. It drives the open-drain SCL and SDA lines through two output-enable pins (1 pulls the line low, 0 releases it) and reads both lines back through input pins. A host issues one-cycle commands: open a transfer (START or repeated START followed by an address byte), move one data byte in either direction, or close the transfer with STOP. After each byte the engine pulses `done`, reports the acknowledge it saw, and parks with SCL held low until the next command arrives.

The SCL low and high phases are timed in prescaler ticks. A high phase only begins counting once the synchronized SCL line is actually seen high. A slave that holds SCL low therefore lengthens the low phase for as long as it likes, and the engine never times out. A bus monitor watches the synchronized lines for START and STOP conditions from any master. A new START waits until the bus is free, and then for a further hardware-timed idle gap.

States: `S_IDLE` (lines released, bus not owned), `S_WAIT_FREE` (counting the idle gap), `S_START_A` (SDA low, SCL high), `S_START_B` (both low), `S_BIT_LOW` (SCL low, SDA set up), `S_BIT_HIGH` (SCL released, sampled at phase end), `S_HOLD` (byte finished, SCL held low), `S_RS_A`/`S_RS_B` (SDA released, then SCL released, before a repeated START), `S_STOP_A`/`S_STOP_B`/`S_STOP_C` (SDA low, SCL released, SDA released). The transitions are:
- IDLE→WAIT_FREE on `req_start`.
- WAIT_FREE→START_A→START_B→BIT_LOW, each on phase end.
- BIT_LOW→BIT_HIGH on phase end.
- BIT_HIGH→BIT_LOW after bits 1 to 8, and BIT_HIGH→HOLD after the ninth bit.
- HOLD→RS_A on `req_start`, HOLD→STOP_A on `req_stop`, HOLD→BIT_LOW on `req_byte`.
- RS_A→RS_B→START_A on phase end.
- STOP_A→STOP_B→STOP_C→IDLE on phase end.
- Any state→IDLE when `en` is low.

Top module: `i2c_byte_master`

## Requirements
- R1: While `en` is 1 the prescaler gives one tick every `div`+1 clock cycles, and each SCL high phase lasts `HALF_TICKS` ticks, counted once SCL is seen high.
- R2: A START (SDA pulled low while SCL is released, then SCL pulled low) is launched only while `bus_busy` is 0 and after `FREE_TICKS` ticks of continuous bus idle.
- R3: `bus_busy` goes to 1 when SDA falls while SCL is high, and goes to 0 when SDA rises while SCL is high. Both lines are seen through a two-flop synchronizer.
- R4: The first byte after a START is always transmitted from `wdata`, MSB first. Its bit 0 is the direction bit, with 1 meaning read.
- R5: Outside START and STOP, SDA changes only while SCL is held low by the engine.
- R6: On the ninth clock of a transmitted byte, `ack_rcvd` becomes 1 if SDA was low and 0 if it was high. After the ninth clock `done` pulses for one cycle while SCL is held low and `ready` is 1.
- R7: In a received byte SDA is released for eight clocks and the bits are collected MSB first into `rdata`. On the ninth clock SDA is pulled low when `ack_ctl` is 1 and released (NACK) when it is 0.
- R8: A slave holding SCL low stretches the low phase without limit. The following high phase still lasts its full length.
- R9: `req_start` while parked after a byte gives a repeated START with no STOP in between.
- R10: `req_stop` gives a STOP: SDA is pulled low while SCL is low, SCL is released, and after a high phase SDA is released. The engine then returns to idle with both lines released.
- R11: The cycle after `en` is sampled 0, both output enables are 0, `ready` is 1 and the engine is idle.
- R12: `req_start` is taken only in IDLE or HOLD. `req_byte` and `req_stop` are taken only in HOLD and are ignored in any other state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Engine enable; 0 releases the lines and forces idle |
| div | input | DIV_W | Prescaler divisor; tick period is div+1 cycles |
| req_start | input | 1 | Pulse: START or repeated START, then send `wdata` as address |
| req_byte | input | 1 | Pulse: transfer one data byte |
| req_stop | input | 1 | Pulse: issue STOP |
| tx_mode | input | 1 | 1 = data byte is transmitted, 0 = received |
| wdata | input | 8 | Address or data byte to send |
| ack_ctl | input | 1 | Receive mode: 1 = send ACK, 0 = send NACK |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| rdata | output | 8 | Byte collected from the line |
| ready | output | 1 | Engine idle or parked; commands may be issued |
| done | output | 1 | One-cycle pulse at the end of a byte |
| ack_rcvd | output | 1 | 1 when SDA was low on the last ninth clock |
| bus_busy | output | 1 | Bus currently owned by some master |

## Verification
The release of both lines after `en` falls is due on the first clock edge that samples `en` low, so the bench drops `en` at a falling edge and checks the enables at the next falling edge. `done`, `ack_rcvd` and `rdata` are produced at the edge that ends the ninth high phase. That edge's timing depends on stretching and on the free-running prescaler, so the bench does not count cycles for them: it waits for the `done` pulse and samples the results in that same half cycle. `bus_busy` trails a line event by three cycles (two synchronizer flops and the flag), so the bench waits at least five cycles after a bus condition before reading it. Phase lengths are measured on the wired lines in nanoseconds and compared with bounds derived from `div` and `HALF_TICKS`.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
    typedef enum logic [3:0] {
        S_IDLE,
        S_WAIT_FREE,
        S_START_A,
        S_START_B,
        S_BIT_LOW,
        S_BIT_HIGH,
        S_HOLD,
        S_RS_A,
        S_RS_B,
        S_STOP_A,
        S_STOP_B,
        S_STOP_C
    } eng_state_e;
endpackage

// File: rtl/i2cm_sync.sv
module i2cm_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '1;
            q      <= '1;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/i2cm_tick.sv
module i2cm_tick #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            tick  <= 1'b0;
        end else if (!en) begin
            cnt_q <= '0;
            tick  <= 1'b0;
        end else if (cnt_q == div) begin
            cnt_q <= '0;
            tick  <= 1'b1;
        end else begin
            cnt_q <= cnt_q + 1'b1;
            tick  <= 1'b0;
        end
    end

    // R1: with a nonzero divisor, ticks never come back to back
    a_r1_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && en && div != '0 && $stable(div)) |=> !tick);
endmodule

// File: rtl/i2cm_busmon.sv
module i2cm_busmon (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic bus_busy
);
    logic scl_p, sda_p;
    logic start_seen, stop_seen;

    assign start_seen = scl_p && scl_s && sda_p && !sda_s;
    assign stop_seen  = scl_p && scl_s && !sda_p && sda_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p    <= 1'b1;
            sda_p    <= 1'b1;
            bus_busy <= 1'b0;
        end else begin
            scl_p <= scl_s;
            sda_p <= sda_s;
            if (start_seen)     bus_busy <= 1'b1;
            else if (stop_seen) bus_busy <= 1'b0;
        end
    end

    a_r3_busy_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        start_seen |=> bus_busy);
    a_r3_free_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
        stop_seen |=> !bus_busy);
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
    import i2cm_pkg::*;
#(
    parameter int DIV_W      = 16,
    parameter int HALF_TICKS = 2,
    parameter int FREE_TICKS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    input  logic             req_start,
    input  logic             req_byte,
    input  logic             req_stop,
    input  logic             tx_mode,
    input  logic [7:0]       wdata,
    input  logic             ack_ctl,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             scl_oe,
    output logic             sda_oe,
    output logic [7:0]       rdata,
    output logic             ready,
    output logic             done,
    output logic             ack_rcvd,
    output logic             bus_busy
);
    // HALF_TICKS must be at least 2 so SDA moves strictly inside the low phase
    localparam int MAXT  = (FREE_TICKS > HALF_TICKS) ? FREE_TICKS : HALF_TICKS;
    localparam int CNT_W = $clog2(MAXT + 1);
    localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(HALF_TICKS - 1);
    localparam logic [CNT_W-1:0] FREE_LAST = CNT_W'(FREE_TICKS - 1);

    eng_state_e       st_q, st_d;
    logic [CNT_W-1:0] ph_cnt;
    logic [3:0]       bit_idx;
    logic [7:0]       shreg;
    logic             xmit_q, ackc_q, sda_q;
    logic             tick, scl_s, sda_s;
    logic             counting, ph_done, wait_hi, sda_want;
    logic [CNT_W-1:0] ph_last;

    i2cm_sync #(.W(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q({scl_s, sda_s})
    );

    i2cm_tick #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .en(en), .div(div), .tick(tick)
    );

    i2cm_busmon u_busmon (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s), .bus_busy(bus_busy)
    );

    // phase timing: high phases count only once SCL is seen high
    always_comb begin
        wait_hi = (st_q == S_BIT_HIGH) || (st_q == S_RS_B) || (st_q == S_STOP_B);
        if (st_q == S_WAIT_FREE)                    counting = !bus_busy;
        else if (st_q == S_IDLE || st_q == S_HOLD)  counting = 1'b0;
        else                                        counting = !wait_hi || scl_s;
        ph_last = (st_q == S_WAIT_FREE) ? FREE_LAST : HALF_LAST;
        ph_done = tick && counting && (ph_cnt == ph_last);
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_IDLE:      if (req_start) st_d = S_WAIT_FREE;
            S_WAIT_FREE: if (ph_done) st_d = S_START_A;
            S_START_A:   if (ph_done) st_d = S_START_B;
            S_START_B:   if (ph_done) st_d = S_BIT_LOW;
            S_BIT_LOW:   if (ph_done) st_d = S_BIT_HIGH;
            S_BIT_HIGH:  if (ph_done) st_d = (bit_idx == 4'd8) ? S_HOLD : S_BIT_LOW;
            S_HOLD: begin
                if (req_start)     st_d = S_RS_A;
                else if (req_stop) st_d = S_STOP_A;
                else if (req_byte) st_d = S_BIT_LOW;
            end
            S_RS_A:      if (ph_done) st_d = S_RS_B;
            S_RS_B:      if (ph_done) st_d = S_START_A;
            S_STOP_A:    if (ph_done) st_d = S_STOP_B;
            S_STOP_B:    if (ph_done) st_d = S_STOP_C;
            S_STOP_C:    if (ph_done) st_d = S_IDLE;
            default:     st_d = S_IDLE;
        endcase
        if (!en) st_d = S_IDLE;
    end

    // SDA level wanted during SCL-low states (1 = pull low)
    always_comb begin
        unique case (st_q)
            S_BIT_LOW: begin
                if (bit_idx < 4'd8) sda_want = xmit_q ? !shreg[7] : 1'b0;
                else                sda_want = xmit_q ? 1'b0 : ackc_q;
            end
            S_STOP_A: sda_want = 1'b1;
            default:  sda_want = 1'b0;
        endcase
    end

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= S_IDLE;
            ph_cnt   <= '0;
            bit_idx  <= '0;
            shreg    <= '0;
            xmit_q   <= 1'b0;
            ackc_q   <= 1'b0;
            sda_q    <= 1'b0;
            done     <= 1'b0;
            ack_rcvd <= 1'b0;
        end else begin
            st_q <= st_d;
            done <= 1'b0;
            if (!en || st_d != st_q)                  ph_cnt <= '0;
            else if (st_q == S_WAIT_FREE && bus_busy) ph_cnt <= '0;
            else if (tick && counting)                ph_cnt <= ph_cnt + 1'b1;

            if (!en) begin
                bit_idx <= '0;
                sda_q   <= 1'b0;
            end else begin
                if ((st_q == S_IDLE || st_q == S_HOLD) && req_start) begin
                    shreg   <= wdata;
                    xmit_q  <= 1'b1;
                    bit_idx <= '0;
                end else if (st_q == S_HOLD && !req_stop && req_byte) begin
                    shreg   <= wdata;
                    xmit_q  <= tx_mode;
                    ackc_q  <= ack_ctl;
                    bit_idx <= '0;
                end
                if (tick && ph_cnt == '0 && (st_q == S_BIT_LOW || st_q == S_HOLD ||
                                             st_q == S_RS_A || st_q == S_STOP_A))
                    sda_q <= sda_want;
                if (st_q == S_START_B) sda_q <= 1'b1;
                if (st_q == S_BIT_HIGH && ph_done) begin
                    if (bit_idx < 4'd8) begin
                        shreg <= {shreg[6:0], sda_s};
                    end else begin
                        ack_rcvd <= !sda_s;
                        done     <= 1'b1;
                    end
                    bit_idx <= bit_idx + 4'd1;
                end
            end
        end
    end

    // outputs
    always_comb begin
        scl_oe = 1'b0;
        sda_oe = sda_q;
        unique case (st_q)
            S_START_A:                   sda_oe = 1'b1;
            S_START_B: begin scl_oe = 1'b1; sda_oe = 1'b1; end
            S_IDLE, S_WAIT_FREE, S_STOP_C: sda_oe = 1'b0;
            S_BIT_LOW, S_HOLD, S_RS_A, S_STOP_A: scl_oe = 1'b1;
            default: ;
        endcase
        ready = (st_q == S_IDLE) || (st_q == S_HOLD);
        rdata = shreg;
    end

    a_r5_sda_still_while_high: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_BIT_HIGH && $past(st_q) == S_BIT_HIGH) |-> $stable(sda_oe));
    a_r8_wait_for_scl: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_BIT_HIGH && !scl_s && en) |=> (st_q == S_BIT_HIGH));
    a_r2_no_start_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_WAIT_FREE && bus_busy) |=> (st_q != S_START_A));
    a_r11_release_on_disable: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!scl_oe && !sda_oe));
    a_r6_done_parks_low: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (scl_oe && ready));
endmodule

// File: tb/test_i2c_byte_master.sv
`timescale 1ns/1ps
module test_i2c_byte_master;
    localparam int DIV   = 3;
    localparam int HALF  = 2;
    localparam int FREE  = 4;
    localparam real TCK  = 5.0;

    // vector: [31:25] addr, [24] read, [23:16] data, [15] slave acks, [14] ack_ctl, [7:0] stretch
    localparam logic [31:0] VEC [4] = '{
        {7'h50, 1'b0, 8'hA5, 1'b1, 1'b0, 6'd0, 8'd0},
        {7'h2B, 1'b1, 8'h3C, 1'b1, 1'b0, 6'd0, 8'd0},
        {7'h11, 1'b0, 8'h0F, 1'b0, 1'b0, 6'd0, 8'd20},
        {7'h7E, 1'b1, 8'hC3, 1'b1, 1'b0, 6'd0, 8'd30}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic [15:0] div = 16'(DIV);
    logic req_start = 1'b0, req_byte = 1'b0, req_stop = 1'b0;
    logic tx_mode = 1'b1, ack_ctl = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic scl_oe, sda_oe, ready, done, ack_rcvd, bus_busy;
    logic [7:0] rdata;

    logic s_scl_hold = 1'b0, s_sda_drv = 1'b0, ext_sda = 1'b0;
    logic scl_line, sda_line;
    assign scl_line = !(scl_oe || s_scl_hold);
    assign sda_line = !(sda_oe || s_sda_drv || ext_sda);

    logic slave_ack = 1'b1;
    logic [7:0] slave_tx = 8'h00;
    int stretch = 0;

    int n_chk = 0, n_fail = 0;

    i2c_byte_master #(.DIV_W(16), .HALF_TICKS(HALF), .FREE_TICKS(FREE)) i_i2c_byte_master (
        .clk(clk), .rst_n(rst_n), .en(en), .div(div),
        .req_start(req_start), .req_byte(req_byte), .req_stop(req_stop),
        .tx_mode(tx_mode), .wdata(wdata), .ack_ctl(ack_ctl),
        .scl_i(scl_line), .sda_i(sda_line), .scl_oe(scl_oe), .sda_oe(sda_oe),
        .rdata(rdata), .ready(ready), .done(done), .ack_rcvd(ack_rcvd), .bus_busy(bus_busy)
    );

    always #2.5 clk = ~clk;

    // bus monitor and slave model
    logic pscl = 1'b1, psda = 1'b1;
    int start_cnt = 0, stop_cnt = 0, sbit = 0;
    logic first = 1'b0, reading = 1'b0, mack = 1'b1;
    logic [7:0] sh = 8'h00, addr_seen = 8'h00, last_byte = 8'h00;
    real t_fall = 0.0, t_rise = 0.0, t_stop = 0.0, gap = 1.0e9;
    real low_max = 0.0, min_high = 1.0e9;

    always @(scl_line, sda_line) begin
        if (scl_line && pscl && psda && !sda_line) begin
            start_cnt = start_cnt + 1;
            gap = $realtime - t_stop;
            sbit = 0; first = 1'b1; reading = 1'b0;
            low_max = 0.0; min_high = 1.0e9;
        end else if (scl_line && pscl && !psda && sda_line) begin
            stop_cnt = stop_cnt + 1;
            t_stop = $realtime;
            s_sda_drv = 1'b0;
        end
        if (scl_line && !pscl) begin
            if ($realtime - t_fall > low_max) low_max = $realtime - t_fall;
            t_rise = $realtime;
            sbit = sbit + 1;
            if (sbit <= 8) sh = {sh[6:0], sda_line};
            if (sbit == 8) begin
                last_byte = sh;
                if (first) addr_seen = sh;
            end
            if (sbit == 9) mack = sda_line;
        end
        if (!scl_line && pscl) begin
            if ($realtime - t_rise < min_high) min_high = $realtime - t_rise;
            t_fall = $realtime;
            if (sbit == 8) begin
                s_sda_drv = (first || !reading) ? slave_ack : 1'b0;
            end else if (sbit == 9) begin
                logic was_first;
                was_first = first;
                if (first) begin first = 1'b0; reading = addr_seen[0]; end
                sbit = 0;
                s_sda_drv = (reading && (was_first || !mack)) ? !slave_tx[7] : 1'b0;
            end else if (reading && sbit >= 1 && sbit <= 7) begin
                s_sda_drv = !slave_tx[7 - sbit];
            end
        end
        pscl = scl_line;
        psda = sda_line;
    end

    always @(negedge scl_line) begin
        if (stretch != 0) begin
            s_scl_hold = 1'b1;
            #(stretch * TCK);
            s_scl_hold = 1'b0;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_ready();
        do @(negedge clk); while (!ready);
    endtask

    task automatic wait_done();
        do @(negedge clk); while (!done);
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (!(ready && !scl_oe && !sda_oe));
        repeat (6) @(negedge clk);
    endtask

    task automatic cmd_start(input logic [7:0] b);
        wait_ready();
        wdata = b; req_start = 1'b1;
        @(negedge clk); req_start = 1'b0;
    endtask

    task automatic cmd_byte(input logic tx, input logic [7:0] b, input logic ac);
        wait_ready();
        tx_mode = tx; wdata = b; ack_ctl = ac; req_byte = 1'b1;
        @(negedge clk); req_byte = 1'b0;
    endtask

    task automatic cmd_stop();
        wait_ready();
        req_stop = 1'b1;
        @(negedge clk); req_stop = 1'b0;
    endtask

    task automatic run_tests();
        int st0, sp0;
        // reset state
        repeat (4) @(negedge clk);
        check(scl_oe == 1'b0, "R11 reset scl_oe", 32'(scl_oe), 0);
        check(sda_oe == 1'b0, "R11 reset sda_oe", 32'(sda_oe), 0);
        check(ready == 1'b1, "R11 reset ready", 32'(ready), 1);
        check(done == 1'b0, "R6 reset done", 32'(done), 0);
        check(bus_busy == 1'b0, "R3 reset bus_busy", 32'(bus_busy), 0);
        rst_n = 1'b1; en = 1'b1;
        repeat (3) @(negedge clk);

        // R12: byte and stop requests in IDLE are ignored
        req_byte = 1'b1; req_stop = 1'b1;
        @(negedge clk); req_byte = 1'b0; req_stop = 1'b0;
        repeat (100) @(negedge clk);
        check(!scl_oe && !sda_oe && start_cnt == 0, "R12 idle ignores byte/stop",
              {scl_oe, sda_oe, 30'(start_cnt)}, 0);

        // table-driven transfers
        for (int v = 0; v < 4; v++) begin
            logic [31:0] e;
            e = VEC[v];
            slave_ack = e[15]; slave_tx = e[23:16]; stretch = int'(e[7:0]);
            sp0 = stop_cnt;
            cmd_start(e[31:24]);
            wait_done();
            check(addr_seen == e[31:24], "R4 address byte on bus", addr_seen, e[31:24]);
            check(ack_rcvd == e[15], "R6 address ack", ack_rcvd, e[15]);
            if (v > 0) check(gap >= (FREE - 1) * (DIV + 1) * TCK, "R2 bus-free gap",
                             32'(int'(gap)), 32'((FREE - 1) * (DIV + 1) * 5));
            cmd_byte(!e[24], e[23:16], e[14]);
            wait_done();
            if (e[24]) begin
                check(rdata == e[23:16], "R7 received byte", rdata, e[23:16]);
                check(mack == !e[14], "R7 master ack bit", mack, !e[14]);
            end else begin
                check(last_byte == e[23:16], "R5 sent data byte", last_byte, e[23:16]);
                check(ack_rcvd == e[15], "R6 data ack", ack_rcvd, e[15]);
            end
            if (stretch != 0) begin
                check(low_max >= stretch * TCK, "R8 low phase stretched",
                      32'(int'(low_max)), 32'(stretch * 5));
                check(min_high >= ((HALF - 1) * (DIV + 1) + 1) * TCK, "R8 full high after stretch",
                      32'(int'(min_high)), 32'(((HALF - 1) * (DIV + 1) + 1) * 5));
            end else begin
                check(min_high >= ((HALF - 1) * (DIV + 1) + 1) * TCK &&
                      min_high <= (HALF * (DIV + 1) + 4) * TCK, "R1 high phase length",
                      32'(int'(min_high)), 32'(HALF * (DIV + 1) * 5));
            end
            cmd_stop();
            wait_idle();
            check(stop_cnt == sp0 + 1, "R10 stop seen", 32'(stop_cnt), 32'(sp0 + 1));
            check(bus_busy == 1'b0, "R3 busy cleared after stop", 32'(bus_busy), 0);
        end
        stretch = 0;

        // R2/R3: foreign START blocks a new one
        ext_sda = 1'b1;
        repeat (10) @(negedge clk);
        check(bus_busy == 1'b1, "R3 busy on foreign start", 32'(bus_busy), 1);
        slave_ack = 1'b1;
        cmd_start(8'hA0);
        repeat (200) @(negedge clk);
        check(!scl_oe && !sda_oe, "R2 start held off while busy", {scl_oe, sda_oe}, 0);
        ext_sda = 1'b0;
        wait_done();
        check(addr_seen == 8'hA0, "R2 start after bus frees", addr_seen, 8'hA0);
        check(gap >= (FREE - 1) * (DIV + 1) * TCK, "R2 gap after foreign stop",
              32'(int'(gap)), 32'((FREE - 1) * (DIV + 1) * 5));
        cmd_stop();
        wait_idle();

        // R9: repeated start, two reads with ACK then NACK
        slave_tx = 8'h96;
        cmd_start(8'hA0);
        wait_done();
        cmd_byte(1'b1, 8'h12, 1'b0);
        wait_done();
        st0 = start_cnt; sp0 = stop_cnt;
        cmd_start(8'hA1);
        wait_done();
        check(start_cnt == st0 + 1 && stop_cnt == sp0, "R9 repeated start without stop",
              32'(start_cnt - st0), 1);
        check(addr_seen == 8'hA1, "R9 read address", addr_seen, 8'hA1);
        cmd_byte(1'b0, 8'h00, 1'b1);
        wait_done();
        check(rdata == 8'h96 && mack == 1'b0, "R7 read with ACK", {rdata, 7'd0, mack}, {8'h96, 8'h00});
        cmd_byte(1'b0, 8'h00, 1'b0);
        wait_done();
        check(rdata == 8'h96 && mack == 1'b1, "R7 read with NACK", {rdata, 7'd0, mack}, {8'h96, 8'h01});
        cmd_stop();
        wait_idle();
        check(stop_cnt == sp0 + 1, "R10 stop after reads", 32'(stop_cnt), 32'(sp0 + 1));

        // R11: disable in mid-byte
        cmd_start(8'hA0);
        wait_done();
        cmd_byte(1'b1, 8'hFF, 1'b0);
        repeat (40) @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        check(!scl_oe && !sda_oe && ready, "R11 disable releases lines",
              {scl_oe, sda_oe, ready}, 32'b001);
        repeat (20) @(negedge clk);
        ext_sda = 1'b1;
        repeat (10) @(negedge clk);
        ext_sda = 1'b0;
        repeat (10) @(negedge clk);
        check(bus_busy == 1'b0, "R3 busy cleared by foreign stop", 32'(bus_busy), 0);
    endtask

    initial begin
        bit timed_out;
        timed_out = 1'b0;
        fork
            run_tests();
            begin
                repeat (150000) @(posedge clk);
                timed_out = 1'b1;
            end
        join_any
        disable fork;
        if (timed_out) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule